// File: doc/BRIEF.md
# Serial Word Store with Self-Timed Write

This block models the device side of a small nonvolatile word memory reached over a four-wire synchronous serial link. It holds 256 words of 16 bits. A host selects it by pulling `sel_n` low, toggles `sclk`, and shifts bits in on `sdi`, most significant bit first. Each bit is sampled on a rising `sclk` edge. A frame is a 4-bit start pattern, then a 4-bit command, then an 8-bit address. Write-type commands add a 16-bit data word. A read returns its word on `sdo`, which is driven only while `sdo_oe` is high.

Writes are protected by an enable latch, which is clear after reset. An accepted write starts a self-timed cycle of `WR_CYCLES` system clocks, and the word is stored only when that cycle ends. The `rdy` pin reports whether a cycle is in progress. A host may also poll this status on `sdo` by selecting the block during the cycle. The `wr_abort` input is sampled on the system clock. It cancels a write that is being entered and ends a write cycle that is already running. It has no effect on any other command.

All three serial pins are synchronised to `clk`, and their edges are found from the synchronised samples. The serial clock must therefore stay well below the system clock; a bit period of at least eight system clocks per phase is assumed. The serial pins have no valid/ready handshake: the host must pace its own frames, and back-pressure is signalled only by `rdy`.

Top module: `serial_word_store`

## Requirements
- R1: After reset, `rdy` is 1, `sdo_oe` is 0, every word reads as 0 and the write-enable latch is clear.
- R2: A frame is recognised only after a falling edge on `sel_n`, once the bit sequence 1,0,1,0 has been seen. Any bits before that sequence completes are ignored. After one frame has finished, further bits are ignored until `sel_n` rises and falls again.
- R3: The 4-bit command codes are 1000 = read, 0100 = write, 0011 = set the enable latch, 0000 = clear the enable latch and 0001 = write every word. An unlisted code does nothing. The 8-bit address follows the command and the 16-bit data word follows the address, each sent MSB first.
- R4: For a read, `sdo_oe` rises after the falling `sclk` edge that ends the 16th bit of the frame. D15 through D0 are then presented, each bit changing after a falling edge. `sdo_oe` drops after the falling edge that ends the 32nd bit.
- R5: An accepted write stores its data word at its address when the write cycle ends, and a later read returns that word.
- R6: A write or write-all sent while the enable latch is clear is ignored: `rdy` stays 1 and memory is unchanged. The latch has no effect on reads.
- R7: An accepted write-all command stores its data word in all 256 locations.
- R8: `rdy` falls after the rising edge of the 32nd bit of an accepted write and stays low for `WR_CYCLES` system clocks before it returns high. `sel_n` has no effect on `rdy`.
- R9: If `sel_n` falls while a write cycle runs, `sdo_oe` goes high and `sdo` shows 0 while busy, then 1 once the cycle is done. `sdo_oe` drops when `sel_n` rises, or when a 1 is sampled on `sdi` after the cycle is done.
- R10: If `wr_abort` is high at any point while a write is being entered, that write is not started. `rdy` stays 1, the word is unchanged and `sdo_oe` stays 0.
- R11: If `wr_abort` is high during a write cycle, `rdy` returns to 1 on the next system clock and the target word keeps its old value.
- R12: `wr_abort` has no effect on reads or on either latch command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sel_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, sampled on rising `sclk` |
| wr_abort | input | 1 | Active-high write abort, synchronous to `clk` |
| sdo | output | 1 | Serial data out (read data or status) |
| sdo_oe | output | 1 | Output enable for `sdo`; 0 means high impedance |
| rdy | output | 1 | 1 when no write cycle is in progress |

## Verification
The bench sends junk bits ahead of a start pattern. A design that treats any sliding four-bit match wrongly, or one that does not wait for the pattern, would return the wrong word. A second command is sent without releasing select, and a block that accepted it would drive `sdo`. The write cycle is timed on both sides of its end, and the status display on `sdo` is checked through busy, done and the clearing 1. The abort input is pulsed during entry and during the cycle, and a design that stored the word anyway, or left `rdy` low, would show up on a read-back. The abort is also held across read and latch commands, where a design that wrongly gated them would fail a later write or read.

// File: rtl/sws_pkg.sv
package sws_pkg;

  // four-bit marker that must precede every command
  localparam logic [3:0] START_PAT = 4'b1010;

  typedef enum logic [3:0] {
    OPC_LOCK  = 4'b0000,
    OPC_FILL  = 4'b0001,
    OPC_OPEN  = 4'b0011,
    OPC_WRITE = 4'b0100,
    OPC_READ  = 4'b1000
  } opc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_OPC,
    ST_ADR,
    ST_DAT,
    ST_RDW,
    ST_RD,
    ST_DONE
  } frame_st_e;

endpackage

// File: rtl/sws_pin_sync.sv
module sws_pin_sync #(
  parameter int unsigned N      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [N-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  for (genvar s = 0; s < STAGES; s++) begin : stg
    logic [N-1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= INIT;
        else        q <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= INIT;
        else        q <= stg[s-1].q;
      end
    end
  end

  assign dout = stg[STAGES-1].q;

endmodule

// File: rtl/sws_word_array.sv
module sws_word_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              we_all,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (we) begin
      for (int w = 0; w < DEPTH; w++)
        if (we_all || (waddr == ADDR_W'(w))) mem[w] <= wdata;
    end
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sws_write_timer.sv
module sws_write_timer #(
  parameter int unsigned WR_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic abort,
  output logic busy,
  output logic commit
);

  localparam int unsigned CW = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WR_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (go) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (abort) begin
      busy <= 1'b0;
    end else if (cnt == LAST) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign commit = busy && !abort && (cnt == LAST);

  // R11: an abort seen while busy ends the cycle on the next clock
  p_abort_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> !busy);

  // R8: busy only ends at the terminal count or through an abort
  p_busy_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(abort) || ($past(cnt) == LAST)));

  // R5: storing the word closes the cycle
  p_commit_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);

endmodule

// File: rtl/sws_frame_engine.sv
module sws_frame_engine
  import sws_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_lo,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              sdi_s,
  input  logic              hw_abort,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_go,
  output logic              wr_all,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);

  localparam int unsigned MAXF = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int unsigned CNT_W = $clog2(MAXF) + 1;

  frame_st_e         st;
  logic [2:0]        win;
  logic [3:0]        op;
  logic [ADDR_W-1:0] adr;
  logic [DATA_W-2:0] dat;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rd_sr;
  logic              oe_rd;
  logic              wen;
  logic              abrt;
  logic              stat;

  assign rd_addr = {adr[ADDR_W-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      win     <= '0;
      op      <= '0;
      adr     <= '0;
      dat     <= '0;
      cnt     <= '0;
      rd_sr   <= '0;
      oe_rd   <= 1'b0;
      wen     <= 1'b0;
      abrt    <= 1'b0;
      stat    <= 1'b0;
      wr_go   <= 1'b0;
      wr_all  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_go <= 1'b0;
      if (sel_lo && hw_abort) abrt <= 1'b1;
      if (sel_fall) begin
        st    <= ST_HUNT;
        win   <= '0;
        cnt   <= '0;
        oe_rd <= 1'b0;
        abrt  <= hw_abort;
        stat  <= busy;
      end else if (sel_rise) begin
        st    <= ST_IDLE;
        oe_rd <= 1'b0;
        stat  <= 1'b0;
      end else if (sel_lo) begin
        if (sck_rise && sdi_s && !busy) stat <= 1'b0;
        case (st)
          ST_HUNT: if (sck_rise) begin
            win <= {win[1:0], sdi_s};
            if ({win, sdi_s} == START_PAT) begin
              st  <= ST_OPC;
              cnt <= '0;
            end
          end
          ST_OPC: if (sck_rise) begin
            op <= {op[2:0], sdi_s};
            if (cnt == CNT_W'(3)) begin
              st  <= ST_ADR;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADR: if (sck_rise) begin
            adr <= rd_addr;
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              cnt <= '0;
              case (op)
                OPC_READ: begin
                  rd_sr <= rd_word;
                  st    <= ST_RDW;
                end
                OPC_WRITE, OPC_FILL: st <= ST_DAT;
                OPC_OPEN: begin
                  wen <= 1'b1;
                  st  <= ST_DONE;
                end
                OPC_LOCK: begin
                  wen <= 1'b0;
                  st  <= ST_DONE;
                end
                default: st <= ST_DONE;
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DAT: if (sck_rise) begin
            dat <= {dat[DATA_W-3:0], sdi_s};
            if (cnt == CNT_W'(DATA_W - 1)) begin
              st <= ST_DONE;
              if (wen && !abrt && !hw_abort && !busy) begin
                wr_go   <= 1'b1;
                wr_addr <= adr;
                wr_data <= {dat, sdi_s};
                wr_all  <= (op == OPC_FILL);
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_RDW: if (sck_fall) begin
            oe_rd <= 1'b1;
            st    <= ST_RD;
            cnt   <= '0;
          end
          ST_RD: if (sck_fall) begin
            if (cnt == CNT_W'(DATA_W - 1)) begin
              oe_rd <= 1'b0;
              st    <= ST_DONE;
            end else begin
              rd_sr <= {rd_sr[DATA_W-2:0], 1'b0};
              cnt   <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdo_oe = oe_rd || stat;
  assign sdo    = oe_rd ? rd_sr[DATA_W-1] : (stat && !busy);

  // R6: a write cycle is only requested while the latch was set
  p_write_needs_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> $past(wen));

  // R9: data out is only driven while the block was selected
  p_oe_selected_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> $past(sel_lo));

  // R10: no write request if abort was high during the final data bit
  p_abort_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> !$past(hw_abort));

endmodule

// File: rtl/serial_word_store.sv
module serial_word_store #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned WR_CYCLES   = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic sclk,
  input  logic sdi,
  input  logic wr_abort,
  output logic sdo,
  output logic sdo_oe,
  output logic rdy
);

  logic [2:0] pins_s;
  logic       sck_s, sel_lo, sdi_s;
  logic [1:0] prv;
  logic       sck_rise, sck_fall, sel_fall, sel_rise;

  logic              busy, commit;
  logic              wr_go, wr_all;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_word;

  sws_pin_sync #(
    .N      (3),
    .STAGES (SYNC_STAGES),
    .INIT   (3'b000)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({sdi, ~sel_n, sclk}),
    .dout  (pins_s)
  );

  assign sck_s  = pins_s[0];
  assign sel_lo = pins_s[1];
  assign sdi_s  = pins_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prv <= 2'b00;
    else        prv <= {sel_lo, sck_s};
  end

  assign sck_rise = sck_s & ~prv[0];
  assign sck_fall = ~sck_s & prv[0];
  assign sel_fall = sel_lo & ~prv[1];
  assign sel_rise = ~sel_lo & prv[1];

  sws_frame_engine #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_lo   (sel_lo),
    .sel_fall (sel_fall),
    .sel_rise (sel_rise),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .sdi_s    (sdi_s),
    .hw_abort (wr_abort),
    .busy     (busy),
    .rd_word  (rd_word),
    .rd_addr  (rd_addr),
    .wr_go    (wr_go),
    .wr_all   (wr_all),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe)
  );

  sws_write_timer #(
    .WR_CYCLES (WR_CYCLES)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .go     (wr_go),
    .abort  (wr_abort),
    .busy   (busy),
    .commit (commit)
  );

  sws_word_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (commit),
    .we_all (wr_all),
    .waddr  (wr_addr),
    .wdata  (wr_data),
    .raddr  (rd_addr),
    .rdata  (rd_word)
  );

  assign rdy = ~busy;

  // R8: ready only falls right after the engine requested a write
  p_rdy_fall_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(wr_go));

  // R5: a write request is never issued on top of a running cycle
  p_go_when_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |-> rdy);

endmodule

// File: tb/serial_word_store_test.sv
module serial_word_store_test;

  localparam int HALF = 8;
  // R3: command codes as seen on the wire
  localparam logic [3:0] C_RD   = 4'b1000;
  localparam logic [3:0] C_WR   = 4'b0100;
  localparam logic [3:0] C_EN   = 4'b0011;
  localparam logic [3:0] C_DIS  = 4'b0000;
  localparam logic [3:0] C_FILL = 4'b0001;

  // {kind, accept, addr, data}: kind 0 write, 1 read, 2 enable, 3 disable
  localparam logic [26:0] VEC [14] = '{
    {2'd2, 1'b0, 8'h00, 16'h0000},
    {2'd0, 1'b1, 8'h00, 16'hA5C3},
    {2'd0, 1'b1, 8'hFF, 16'h1234},
    {2'd0, 1'b1, 8'h7E, 16'h8001},
    {2'd1, 1'b0, 8'h00, 16'hA5C3},
    {2'd1, 1'b0, 8'hFF, 16'h1234},
    {2'd1, 1'b0, 8'h7E, 16'h8001},
    {2'd1, 1'b0, 8'h01, 16'h0000},
    {2'd3, 1'b0, 8'h00, 16'h0000},
    {2'd0, 1'b0, 8'h00, 16'hFFFF},
    {2'd1, 1'b0, 8'h00, 16'hA5C3},
    {2'd2, 1'b0, 8'h00, 16'h0000},
    {2'd0, 1'b1, 8'h00, 16'h0F0F},
    {2'd1, 1'b0, 8'h00, 16'h0F0F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic wr_abort = 1'b0;
  logic sdo, sdo_oe, rdy;

  int nchk = 0;
  int nfail = 0;
  int oe_cnt;
  logic oe_end;
  bit done = 1'b0;

  always #10 clk = ~clk;

  serial_word_store uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (sel_n),
    .sclk     (sclk),
    .sdi      (sdi),
    .wr_abort (wr_abort),
    .sdo      (sdo),
    .sdo_oe   (sdo_oe),
    .rdy      (rdy)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic clock_bit(input logic b, output logic o, output logic oe);
    sdi = b;
    wait_clk(HALF);
    o  = sdo;
    oe = sdo_oe;
    sclk = 1'b1;
    wait_clk(HALF);
    sclk = 1'b0;
  endtask

  task automatic frame(input logic [3:0] op, input logic [7:0] a, input logic [15:0] d,
                       input int nbits, input int pre, input int abort_at,
                       input bit hold_sel, output logic [15:0] rd);
    logic [31:0] v;
    logic o, oe;
    v = {4'b1010, op, a, d};
    if (!hold_sel) begin
      sel_n = 1'b0;
      wait_clk(4);
    end
    for (int k = 0; k < pre; k++) clock_bit(1'b1, o, oe);
    rd = '0;
    oe_cnt = 0;
    for (int i = 0; i < nbits; i++) begin
      if (i == abort_at) wr_abort = 1'b1;
      if (i == abort_at + 3) wr_abort = 1'b0;
      clock_bit(v[31-i], o, oe);
      if (i >= 16) begin
        rd = {rd[14:0], (oe ? o : 1'b0)};
        if (oe) oe_cnt++;
      end
    end
    wait_clk(6);
    oe_end = sdo_oe;
    if (!hold_sel) sel_n = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic o, oe;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1: reset state
    chk("R1 rdy", {31'd0, rdy}, 32'd1);
    chk("R1 sdo_oe", {31'd0, sdo_oe}, 32'd0);
    frame(C_RD, 8'h10, 16'h0, 32, 0, -1, 1'b0, rd);
    chk("R1 word", {16'd0, rd}, 32'h0);
    frame(C_WR, 8'h10, 16'h7777, 32, 0, -1, 1'b0, rd);
    chk("R1 latch clear", {31'd0, rdy}, 32'd1);

    // table walk: R3, R5, R6
    for (int i = 0; i < 14; i++) begin
      logic [26:0] e;
      e = VEC[i];
      case (e[26:25])
        2'd0: begin
          frame(C_WR, e[23:16], e[15:0], 32, 0, -1, 1'b0, rd);
          chk("R6 write acceptance", {31'd0, rdy}, {31'd0, ~e[24]});
          wait_clk(80);
        end
        2'd1: begin
          frame(C_RD, e[23:16], 16'h0, 32, 0, -1, 1'b0, rd);
          chk("R5 read back", {16'd0, rd}, {16'd0, e[15:0]});
        end
        2'd2: frame(C_EN, e[23:16], 16'h0, 16, 0, -1, 1'b0, rd);
        default: frame(C_DIS, e[23:16], 16'h0, 16, 0, -1, 1'b0, rd);
      endcase
    end

    // R2: junk bits ahead of the start pattern
    frame(C_RD, 8'hFF, 16'h0, 32, 3, -1, 1'b0, rd);
    chk("R2 junk prefix", {16'd0, rd}, 32'h1234);
    // R2: second command without a new select edge
    sel_n = 1'b0;
    wait_clk(4);
    frame(C_RD, 8'h7E, 16'h0, 32, 0, -1, 1'b1, rd);
    chk("R2 first in select", {16'd0, rd}, 32'h8001);
    frame(C_RD, 8'h7E, 16'h0, 32, 0, -1, 1'b1, rd);
    chk("R2 second ignored", oe_cnt, 32'd0);
    sel_n = 1'b1;
    wait_clk(8);

    // R4: output enable window of a read
    frame(C_RD, 8'h7E, 16'h0, 32, 0, -1, 1'b0, rd);
    chk("R4 driven bits", oe_cnt, 32'd16);
    chk("R4 released", {31'd0, oe_end}, 32'd0);

    // R7: write every word
    frame(C_FILL, 8'h00, 16'h3C3C, 32, 0, -1, 1'b0, rd);
    wait_clk(80);
    frame(C_RD, 8'h00, 16'h0, 32, 0, -1, 1'b0, rd);
    chk("R7 word 00", {16'd0, rd}, 32'h3C3C);
    frame(C_RD, 8'h80, 16'h0, 32, 0, -1, 1'b0, rd);
    chk("R7 word 80", {16'd0, rd}, 32'h3C3C);
    frame(C_RD, 8'hFF, 16'h0, 32, 0, -1, 1'b0, rd);
    chk("R7 word FF", {16'd0, rd}, 32'h3C3C);

    // R8: ready window, 22 clocks after the last rising sclk on return
    frame(C_WR, 8'h05, 16'hBEEF, 32, 0, -1, 1'b0, rd);
    chk("R8 busy early", {31'd0, rdy}, 32'd0);
    wait_clk(38);
    chk("R8 busy late", {31'd0, rdy}, 32'd0);
    wait_clk(20);
    chk("R8 ready again", {31'd0, rdy}, 32'd1);
    frame(C_RD, 8'h05, 16'h0, 32, 0, -1, 1'b0, rd);
    chk("R5 stored", {16'd0, rd}, 32'hBEEF);

    // R9: status on data out
    frame(C_WR, 8'h06, 16'h5A5A, 32, 0, -1, 1'b0, rd);
    chk("R9 deselected", {31'd0, sdo_oe}, 32'd0);
    sel_n = 1'b0;
    wait_clk(8);
    chk("R9 busy shown", {30'd0, sdo_oe, sdo}, 32'd2);
    chk("R8 select ignored", {31'd0, rdy}, 32'd0);
    wait_clk(60);
    chk("R9 ready shown", {30'd0, sdo_oe, sdo}, 32'd3);
    clock_bit(1'b0, o, oe);
    wait_clk(6);
    chk("R9 zero kept", {30'd0, sdo_oe, sdo}, 32'd3);
    clock_bit(1'b1, o, oe);
    wait_clk(6);
    chk("R9 one clears", {31'd0, sdo_oe}, 32'd0);
    sel_n = 1'b1;
    wait_clk(8);

    // R11: abort during the write cycle
    frame(C_WR, 8'h05, 16'h1111, 32, 0, -1, 1'b0, rd);
    wr_abort = 1'b1;
    wait_clk(2);
    chk("R11 ready at once", {31'd0, rdy}, 32'd1);
    wr_abort = 1'b0;
    wait_clk(80);
    frame(C_RD, 8'h05, 16'h0, 32, 0, -1, 1'b0, rd);
    chk("R11 word kept", {16'd0, rd}, 32'hBEEF);

    // R10: abort during entry of a write
    frame(C_WR, 8'h05, 16'h2222, 32, 0, 10, 1'b0, rd);
    chk("R10 not started", {31'd0, rdy}, 32'd1);
    chk("R10 output quiet", oe_cnt, 32'd0);
    wait_clk(80);
    frame(C_RD, 8'h05, 16'h0, 32, 0, -1, 1'b0, rd);
    chk("R10 word kept", {16'd0, rd}, 32'hBEEF);

    // R12: abort held across read and latch commands
    wr_abort = 1'b1;
    frame(C_RD, 8'h05, 16'h0, 32, 0, -1, 1'b0, rd);
    chk("R12 read unaffected", {16'd0, rd}, 32'hBEEF);
    frame(C_DIS, 8'h00, 16'h0, 16, 0, -1, 1'b0, rd);
    wr_abort = 1'b0;
    frame(C_WR, 8'h05, 16'h3333, 32, 0, -1, 1'b0, rd);
    chk("R12 disable took effect", {31'd0, rdy}, 32'd1);
    wait_clk(80);
    wr_abort = 1'b1;
    frame(C_EN, 8'h00, 16'h0, 16, 0, -1, 1'b0, rd);
    wr_abort = 1'b0;
    frame(C_WR, 8'h05, 16'h4444, 32, 0, -1, 1'b0, rd);
    chk("R12 enable took effect", {31'd0, rdy}, 32'd0);
    wait_clk(80);
    frame(C_RD, 8'h05, 16'h0, 32, 0, -1, 1'b0, rd);
    chk("R12 written", {16'd0, rd}, 32'h4444);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule